// File: doc/BRIEF.md
# Shadowed Complementary PWM Phase Gate

This block drives one leg of a motor bridge. It has no counter of its own. It compares a period counter shared by all phases against a duty threshold, and it drives two outputs: a gate signal for the high-side transistor and a shutdown signal for the leg's driver. A wrap strobe marks the cycle in which the shared counter is back at zero. Incoming settings are the threshold and two enable bits. The block takes a new set only at that wrap, and only while a settings-consistent flag is high. A period therefore always runs on one coherent setting, even when the settings source is rewritten part way through.

A trip input puts the leg in its safe state. Both outputs move there on the next clock edge, whatever the setting in force. A synchronous reset gives the same safe state and clears the stored setting. Both outputs are registered, so each output reflects the counter value present one clock earlier.

Top module: `pwm_phase_gate`

## Requirements
- R1: On the first clock edge with `rst` high, and on every edge while it stays high, `gate_hi_o` becomes 0 and `gate_off_o` becomes 1. The stored setting is cleared to threshold 0, drive enable 0 and shutdown enable 1, so the leg stays safe after reset until a setting is loaded.
- R2: Outside reset and trip, `gate_hi_o` after an edge is 1 exactly when the effective drive enable was 1 and `cnt_i` was strictly below the effective threshold in the cycle before that edge.
- R3: The effective setting is the incoming one (`match_i`, `drive_en_i`, `shut_en_i`) in a cycle where `wrap_i` and `cfg_ok_i` are both high. In every other cycle it is the stored setting. The incoming setting is stored only in such a cycle.
- R4: When the incoming setting changes in cycles without a wrap, or at a wrap while `cfg_ok_i` is low, the outputs do not change for the rest of that period.
- R5: A threshold of 0 keeps `gate_hi_o` at 0 for a whole period. A threshold of 2^CNT_W-1 keeps it high for every count except the last one.
- R6: Outside reset, `gate_off_o` after an edge is 1 when the effective shutdown enable was 1 or `trip_i` was high in the cycle before that edge.
- R7: When `trip_i` is high in a cycle, the next edge sets `gate_hi_o` to 0 and `gate_off_o` to 1 together. Setting loads at a wrap still take place during a trip. After `trip_i` falls, the next edge resumes the behaviour of R2 and R6 with the stored setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | CNT_W | Shared period counter value |
| wrap_i | input | 1 | High in the cycle in which the counter is back at zero |
| cfg_ok_i | input | 1 | Incoming setting is consistent |
| trip_i | input | 1 | Failsafe request, forces the safe state |
| match_i | input | CNT_W | Incoming duty threshold |
| drive_en_i | input | 1 | Incoming enable for the high-side gate |
| shut_en_i | input | 1 | Incoming request to assert shutdown |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_off_o | output | 1 | Leg shutdown, 1 = driver disabled |

## Verification
A stored setting loaded at the wrong moment appears as a changed pulse width. The error shows up within one period, at the first count where the old and new thresholds fall on different sides of the counter. A stored setting that fails to load shows up the same way, in the period after the missed load. A wrong state in the output registers, or a missing trip override, shows up on the very next edge. For that reason the scoreboard compares both outputs on every cycle, and does not only look at pulse edges. Stimulus covers mid-period rewrites, wraps with the consistent flag low, the two extreme thresholds, and a trip with a load inside it.

// File: rtl/pwm_phase_gate.sv
module pwm_phase_gate #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             cfg_ok_i,
  input  logic             trip_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             drive_en_i,
  input  logic             shut_en_i,
  output logic             gate_hi_o,
  output logic             gate_off_o
);

  logic [CNT_W-1:0] thr_q;
  logic             drv_q;
  logic             sd_q;

  logic             take;
  logic [CNT_W-1:0] thr_eff;
  logic             drv_eff;
  logic             sd_eff;

  assign take    = wrap_i & cfg_ok_i;
  assign thr_eff = take ? match_i    : thr_q;
  assign drv_eff = take ? drive_en_i : drv_q;
  assign sd_eff  = take ? shut_en_i  : sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
      drv_q <= 1'b0;
      sd_q  <= 1'b1;
    end else if (take) begin
      thr_q <= match_i;
      drv_q <= drive_en_i;
      sd_q  <= shut_en_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi_o  <= 1'b0;
      gate_off_o <= 1'b1;
    end else begin
      gate_hi_o  <= ~trip_i & drv_eff & (cnt_i < thr_eff);
      gate_off_o <= trip_i | sd_eff;
    end
  end

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      AST_RESET_SAFE: assert (!gate_hi_o && gate_off_o); // R1
    end
  end

  AST_TRIP_SAFE: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> (!gate_hi_o && gate_off_o)); // R7

  AST_HOLD_SETTING: assert property (@(posedge clk) disable iff (rst)
    !(wrap_i && cfg_ok_i) |=> ($stable(thr_q) && $stable(drv_q) && $stable(sd_q))); // R4

  AST_HI_NEEDS_SETTING: assert property (@(posedge clk) disable iff (rst)
    gate_hi_o |-> (drv_q && thr_q != '0)); // R2

  AST_SHUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    sd_q |-> gate_off_o); // R6

endmodule

// File: tb/tb_pwm_phase_gate.sv
module tb_pwm_phase_gate;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 11;
  localparam int TOP = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             wrap_i = 1'b0;
  logic             cfg_ok_i = 1'b0;
  logic             trip_i = 1'b0;
  logic [CNT_W-1:0] match_i = '0;
  logic             drive_en_i = 1'b0;
  logic             shut_en_i = 1'b0;
  logic             gate_hi_o;
  logic             gate_off_o;

  pwm_phase_gate #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .wrap_i(wrap_i), .cfg_ok_i(cfg_ok_i),
    .trip_i(trip_i), .match_i(match_i), .drive_en_i(drive_en_i),
    .shut_en_i(shut_en_i), .gate_hi_o(gate_hi_o), .gate_off_o(gate_off_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic  hi;
    logic  off;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_thr = 0;
  bit m_drv = 1'b0;
  bit m_sd  = 1'b1;

  task automatic drive(input bit r, input int c, input bit w, input bit ok,
                       input bit t, input int m, input bit de, input bit se,
                       input string req);
    exp_t e;
    int  ethr;
    bit  edrv, esd;
    @(negedge clk);
    rst = r; cnt_i = c[CNT_W-1:0]; wrap_i = w; cfg_ok_i = ok; trip_i = t;
    match_i = m[CNT_W-1:0]; drive_en_i = de; shut_en_i = se;
    e.req = req;
    if (r) begin
      m_thr = 0; m_drv = 1'b0; m_sd = 1'b1;
      e.hi = 1'b0; e.off = 1'b1; e.req = "R1";
    end else begin
      ethr = (w && ok) ? m : m_thr;
      edrv = (w && ok) ? de : m_drv;
      esd  = (w && ok) ? se : m_sd;
      e.hi  = !t && edrv && (c < ethr);
      e.off = t || esd;
      if (w && ok) begin m_thr = m; m_drv = de; m_sd = se; end
    end
    exp_q.push_back(e);
  endtask

  // one full period; settings switch to (m2,de2,se2) at tick chg, trip over [t0,t1)
  task automatic period(input bit ok, input int m, input bit de, input bit se,
                        input int chg, input int m2, input bit de2, input bit se2,
                        input int t0, input int t1, input string req);
    for (int k = 0; k <= TOP; k++) begin
      bit late = (k >= chg);
      drive(1'b0, k, k == 0, ok, (k >= t0) && (k < t1),
            late ? m2 : m, late ? de2 : de, late ? se2 : se, req);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (gate_hi_o !== e.hi || gate_off_o !== e.off) begin
          failures++;
          $display("FAIL %s: hi/off actual=%b%b expected=%b%b at %0t",
                   e.req, gate_hi_o, gate_off_o, e.hi, e.off, $time);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    // R1 reset state, even with active-looking inputs
    for (int i = 0; i < 4; i++) drive(1'b1, 5, 1'b1, 1'b1, 1'b0, 900, 1'b1, 1'b0, "R1");
    // R1 safe after reset: no load yet, counts run
    for (int k = 0; k < 20; k++) drive(1'b0, k, 1'b0, 1'b1, 1'b0, 900, 1'b1, 1'b0, "R1");
    // R2 R3 normal duty 500
    period(1'b1, 500, 1'b1, 1'b0, TOP + 1, 0, 0, 0, TOP + 1, 0, "R2");
    // R4 mid-period rewrite ignored
    period(1'b1, 700, 1'b1, 1'b0, 300, 100, 1'b0, 1'b1, TOP + 1, 0, "R4");
    // R3 rewrite from last period takes effect at this wrap
    period(1'b1, 100, 1'b0, 1'b1, TOP + 1, 0, 0, 0, TOP + 1, 0, "R3");
    // R4 wrap with consistent flag low keeps stored setting
    period(1'b0, 1500, 1'b1, 1'b0, TOP + 1, 0, 0, 0, TOP + 1, 0, "R4");
    // R6 shutdown enable with drive enabled
    period(1'b1, 1200, 1'b1, 1'b1, TOP + 1, 0, 0, 0, TOP + 1, 0, "R6");
    // R5 zero threshold
    period(1'b1, 0, 1'b1, 1'b0, TOP + 1, 0, 0, 0, TOP + 1, 0, "R5");
    // R5 maximum threshold
    period(1'b1, TOP, 1'b1, 1'b0, TOP + 1, 0, 0, 0, TOP + 1, 0, "R5");
    // R7 trip mid-period
    period(1'b1, 1000, 1'b1, 1'b0, TOP + 1, 0, 0, 0, 400, 900, "R7");
    // R7 trip across the wrap: load still happens
    period(1'b1, 1000, 1'b1, 1'b0, TOP + 1, 0, 0, 0, 2000, TOP + 1, "R7");
    period(1'b1, 300, 1'b1, 1'b0, TOP + 1, 0, 0, 0, 0, 50, "R7");
    // R2 drive disabled, shutdown released
    period(1'b1, 800, 1'b0, 1'b0, TOP + 1, 0, 0, 0, TOP + 1, 0, "R2");
    // R1 reset mid-run returns to safe state and clears setting
    for (int i = 0; i < 3; i++) drive(1'b1, i, 1'b0, 1'b1, 1'b0, 800, 1'b1, 1'b0, "R1");
    for (int k = 3; k < 40; k++) drive(1'b0, k, 1'b0, 1'b1, 1'b0, 800, 1'b1, 1'b0, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule